// File: doc/BRIEF.md
# Exception Vector Entry Controller

This block performs the bookkeeping of taking an exception into the kernel privilege level of a 64-bit core. A request strobe carries an exception type code and a snapshot of the interrupted context: the privilege level, the stack-pointer select bit, whether the interrupted code ran 32-bit, whether it was in the compressed instruction set, the PC, the status word, a syndrome value and a fault address. The block also reads a programmable vector base.

One cycle after a request is taken, the block presents the address to fetch next. In the same cycle it gives write strobes and values for the syndrome, fault-address, link and saved-status registers, the status word to install, and a request to swap stack banks. The vector address is the base plus two offsets. The first offset depends on where the exception came from. The second depends on whether the exception is synchronous, IRQ or FIQ. An unknown type code yields only an error pulse. A one-cycle ready gap keeps a second request from arriving on top of the pending result.

Top module: `exc_entry`

## Requirements
- R1: The target address equals the vector base plus a source offset plus a class offset.
- R2: When the level input is 0 (the lowest level), the source offset is 0x400 for 64-bit code (is_32bit=0) and 0x600 for 32-bit code (is_32bit=1).
- R3: When the level input is nonzero (the kernel level), the source offset is 0x200 if sp_sel=1 and 0x000 if sp_sel=0.
- R4: The type codes are 0 prefetch abort, 1 data abort, 2 breakpoint, 3 undefined instruction, 4 supervisor call, 5 IRQ and 6 FIQ. Codes 0 to 4 use class offset 0x000, code 5 uses 0x080 and code 6 uses 0x100.
- R5: The syndrome and fault-address write strobes pulse with the result. The fault-address value equals the supplied fault address. The syndrome value equals the supplied syndrome, except as R7 states.
- R6: The link value equals the interrupted PC, and the saved-status value equals the status word supplied with the request.
- R7: When is_32bit=1 and compressed=0, bit 25 of the syndrome value written is forced to 1. Otherwise the syndrome passes unchanged.
- R8: The new status word is 0x000003C5. Bits 9:6 are the four interrupt masks, all set. Bit 4 is the execution state, 0 meaning 64-bit. Bits 3:0 hold mode 0101, which is the kernel level on its dedicated stack pointer.
- R9: sp_swap pulses with the result only when is_32bit=0, and sp_save_level then reports the interrupted level.
- R10: Type code 7 gives a one-cycle err pulse with no out_valid, no write strobe and no sp_swap.
- R11: A request is taken when req_valid and req_ready are both high at a clock edge. Its results and out_valid (or err) appear after that edge and last exactly one cycle.
- R12: req_ready is low in the cycle out_valid or err is high, so a held request is taken only at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request strobe |
| req_ready | output | 1 | Request can be taken this cycle |
| req_type | input | 3 | Exception type code |
| cur_level | input | 2 | Privilege level when interrupted |
| sp_sel | input | 1 | Stack-pointer select bit of interrupted code |
| is_32bit | input | 1 | Interrupted code ran 32-bit |
| compressed | input | 1 | Interrupted code used the compressed instruction set |
| cur_pc | input | AW | Interrupted PC |
| cur_status | input | 32 | Status word before entry |
| syndrome | input | SW | Syndrome value |
| fault_addr | input | AW | Faulting virtual address |
| vec_base | input | AW | Programmable vector base |
| out_valid | output | 1 | Result pulse |
| err | output | 1 | Unknown type code pulse |
| target_pc | output | AW | Vector address |
| wr_syn | output | 1 | Syndrome register write |
| syn_val | output | SW | Syndrome value to write |
| wr_far | output | 1 | Fault-address register write |
| far_val | output | AW | Fault address to write |
| wr_link | output | 1 | Link register write |
| link_val | output | AW | Return address to write |
| wr_saved | output | 1 | Saved-status register write |
| saved_val | output | 32 | Status word to save |
| new_status | output | 32 | Status word to install |
| sp_swap | output | 1 | Bank current SP and select kernel SP |
| sp_save_level | output | 2 | Level whose SP bank receives the current SP |

## Verification
Two events can coincide in one cycle: the result pulse of one request and a new request waiting at the input. The bench holds req_valid high across a first request and then changes the payload to a second, different request. It checks that ready is low during the pulse and that the first request's target is shown. It then checks that the second request's target appears exactly two cycles later and that it was not taken twice. The same collision is repeated with an unknown code following a valid one, so the err pulse also shows the ready gap.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        EXC_PABT  = 3'd0,
        EXC_DABT  = 3'd1,
        EXC_BKPT  = 3'd2,
        EXC_UNDEF = 3'd3,
        EXC_SVC   = 3'd4,
        EXC_IRQ   = 3'd5,
        EXC_FIQ   = 3'd6,
        EXC_RSVD  = 3'd7
    } exc_code_e;

    typedef enum logic [1:0] {
        CLS_SYNC = 2'd0,
        CLS_IRQ  = 2'd1,
        CLS_FIQ  = 2'd2,
        CLS_BAD  = 2'd3
    } exc_class_e;

    typedef enum logic [1:0] {
        SRC_CUR_SH  = 2'd0,
        SRC_CUR_DED = 2'd1,
        SRC_LOW_64  = 2'd2,
        SRC_LOW_32  = 2'd3
    } exc_src_e;

    localparam int OFF_W      = 12;
    localparam int STAT_W     = 32;
    localparam int LVL_W      = 2;
    localparam int SYN_IL_BIT = 25;

    localparam logic [3:0]        MODE_K_DED   = 4'b0101;
    localparam logic [STAT_W-1:0] ENTRY_STATUS =
        {{(STAT_W-10){1'b0}}, 4'b1111, 1'b0, 1'b0, MODE_K_DED};

    function automatic logic [OFF_W-1:0] src_offset(exc_src_e s);
        case (s)
            SRC_LOW_64:  return 12'h400;
            SRC_LOW_32:  return 12'h600;
            SRC_CUR_DED: return 12'h200;
            default:     return 12'h000;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] class_offset(exc_class_e c);
        case (c)
            CLS_IRQ: return 12'h080;
            CLS_FIQ: return 12'h100;
            default: return 12'h000;
        endcase
    endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
(
    input  logic [2:0] code,
    output exc_class_e cls,
    output logic       legal
);
    always_comb begin
        case (exc_code_e'(code))
            EXC_PABT, EXC_DABT, EXC_BKPT, EXC_UNDEF, EXC_SVC: cls = CLS_SYNC;
            EXC_IRQ: cls = CLS_IRQ;
            EXC_FIQ: cls = CLS_FIQ;
            default: cls = CLS_BAD;
        endcase
        legal = (cls != CLS_BAD);
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_entry_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [AW-1:0]    base,
    input  logic [LVL_W-1:0] level,
    input  logic             sp_sel,
    input  logic             is_32bit,
    input  exc_class_e       cls,
    output logic [AW-1:0]    target
);
    exc_src_e         src;
    logic [OFF_W-1:0] off_sum;

    always_comb begin
        if (level == '0)
            src = is_32bit ? SRC_LOW_32 : SRC_LOW_64;
        else
            src = sp_sel ? SRC_CUR_DED : SRC_CUR_SH;
        // offsets occupy disjoint bits, so a narrow sum cannot carry out
        off_sum = src_offset(src) + class_offset(cls);
        target  = base + {{(AW-OFF_W){1'b0}}, off_sum};
    end
endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome
    import exc_entry_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic [SW-1:0] syn_in,
    input  logic          is_32bit,
    input  logic          compressed,
    output logic [SW-1:0] syn_out
);
    generate
        if (SW > SYN_IL_BIT) begin : g_il
            always_comb begin
                syn_out = syn_in;
                if (is_32bit && !compressed)
                    syn_out[SYN_IL_BIT] = 1'b1;
            end
        end else begin : g_pass
            assign syn_out = syn_in;
        end
    endgenerate
endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_entry_pkg::*;
#(
    parameter int AW = 64,
    parameter int SW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_type,
    input  logic [1:0]        cur_level,
    input  logic              sp_sel,
    input  logic              is_32bit,
    input  logic              compressed,
    input  logic [AW-1:0]     cur_pc,
    input  logic [31:0]       cur_status,
    input  logic [SW-1:0]     syndrome,
    input  logic [AW-1:0]     fault_addr,
    input  logic [AW-1:0]     vec_base,
    output logic              out_valid,
    output logic              err,
    output logic [AW-1:0]     target_pc,
    output logic              wr_syn,
    output logic [SW-1:0]     syn_val,
    output logic              wr_far,
    output logic [AW-1:0]     far_val,
    output logic              wr_link,
    output logic [AW-1:0]     link_val,
    output logic              wr_saved,
    output logic [31:0]       saved_val,
    output logic [31:0]       new_status,
    output logic              sp_swap,
    output logic [1:0]        sp_save_level
);
    exc_class_e    cls;
    logic          legal;
    logic [AW-1:0] tgt_d;
    logic [SW-1:0] syn_d;
    logic          take;

    exc_classify u_cls (
        .code  (req_type),
        .cls   (cls),
        .legal (legal)
    );

    exc_vector #(.AW(AW)) u_vec (
        .base     (vec_base),
        .level    (cur_level),
        .sp_sel   (sp_sel),
        .is_32bit (is_32bit),
        .cls      (cls),
        .target   (tgt_d)
    );

    exc_syndrome #(.SW(SW)) u_syn (
        .syn_in     (syndrome),
        .is_32bit   (is_32bit),
        .compressed (compressed),
        .syn_out    (syn_d)
    );

    assign req_ready = !(out_valid || err);
    assign take      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            err           <= 1'b0;
            sp_swap       <= 1'b0;
            target_pc     <= '0;
            syn_val       <= '0;
            far_val       <= '0;
            link_val      <= '0;
            saved_val     <= '0;
            new_status    <= '0;
            sp_save_level <= '0;
        end else begin
            out_valid <= take && legal;
            err       <= take && !legal;
            sp_swap   <= take && legal && !is_32bit;
            if (take && legal) begin
                target_pc     <= tgt_d;
                syn_val       <= syn_d;
                far_val       <= fault_addr;
                link_val      <= cur_pc;
                saved_val     <= cur_status;
                new_status    <= ENTRY_STATUS;
                sp_save_level <= cur_level;
            end
        end
    end

    assign wr_syn   = out_valid;
    assign wr_far   = out_valid;
    assign wr_link  = out_valid;
    assign wr_saved = out_valid;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int AW = 64,
    parameter int SW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          is_32bit,
    input logic [AW-1:0] cur_pc,
    input logic [31:0]   cur_status,
    input logic [AW-1:0] vec_base,
    input logic          out_valid,
    input logic          err,
    input logic [AW-1:0] target_pc,
    input logic          wr_syn,
    input logic          wr_far,
    input logic          wr_link,
    input logic          wr_saved,
    input logic [AW-1:0] link_val,
    input logic [31:0]   saved_val,
    input logic          sp_swap
);
    localparam logic [AW-1:0] OFF_BITS = AW'(12'h780);

    // R11
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (out_valid || err));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid || err) |-> !req_ready);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !(out_valid || wr_syn || wr_far || wr_link || wr_saved || sp_swap));

    // R1
    target_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((target_pc - $past(vec_base)) & ~OFF_BITS) == '0));

    // R6
    link_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (link_val == $past(cur_pc) && saved_val == $past(cur_status)));

    // R9
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sp_swap == !$past(is_32bit)));
endmodule

bind exc_entry exc_entry_chk #(.AW(AW), .SW(SW)) u_chk (.*);

// File: tb/sim_exc_entry.sv
module sim_exc_entry;
    localparam int AW = 64;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [2:0]    req_type;
    logic [1:0]    cur_level;
    logic          sp_sel;
    logic          is_32bit;
    logic          compressed;
    logic [AW-1:0] cur_pc;
    logic [31:0]   cur_status;
    logic [SW-1:0] syndrome;
    logic [AW-1:0] fault_addr;
    logic [AW-1:0] vec_base;
    logic          out_valid;
    logic          err;
    logic [AW-1:0] target_pc;
    logic          wr_syn;
    logic [SW-1:0] syn_val;
    logic          wr_far;
    logic [AW-1:0] far_val;
    logic          wr_link;
    logic [AW-1:0] link_val;
    logic          wr_saved;
    logic [31:0]   saved_val;
    logic [31:0]   new_status;
    logic          sp_swap;
    logic [1:0]    sp_save_level;

    int nvec  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    exc_entry #(.AW(AW), .SW(SW)) u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_target(input logic [63:0] base, input logic [1:0] lvl,
                                               input logic sps, input logic b32, input logic [2:0] t);
        logic [63:0] a;
        a = base;
        if (lvl == 2'd0) a = a + (b32 ? 64'h600 : 64'h400);
        else if (sps)    a = a + 64'h200;
        if (t == 3'd5)      a = a + 64'h080;
        else if (t == 3'd6) a = a + 64'h100;
        return a;
    endfunction

    task automatic set_req(input logic [2:0] t, input logic [1:0] lvl, input logic sps,
                           input logic b32, input logic cmp, input logic [63:0] pc,
                           input logic [31:0] st, input logic [31:0] syn, input logic [63:0] fa);
        req_type   = t;
        cur_level  = lvl;
        sp_sel     = sps;
        is_32bit   = b32;
        compressed = cmp;
        cur_pc     = pc;
        cur_status = st;
        syndrome   = syn;
        fault_addr = fa;
    endtask

    // one request, all outputs checked one cycle later, then the pulse end
    task automatic do_req(input logic [2:0] t, input logic [1:0] lvl, input logic sps,
                          input logic b32, input logic cmp, input logic [63:0] pc,
                          input logic [31:0] st, input logic [31:0] syn, input logic [63:0] fa);
        logic [31:0] es;
        @(negedge clk);
        set_req(t, lvl, sps, b32, cmp, pc, st, syn, fa);
        req_valid = 1'b1;
        chk("R12 ready idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        es = syn;
        if (b32 && !cmp) es[25] = 1'b1;
        chk("R11 out_valid", out_valid, 1);
        chk("R1/R2/R3/R4 target", target_pc, exp_target(vec_base, lvl, sps, b32, t));
        chk("R5 strobes", {wr_syn, wr_far}, 2'b11);
        chk("R5 far", far_val, fa);
        chk("R5/R7 syndrome", syn_val, es);
        chk("R6 link", link_val, pc);
        chk("R6 saved", saved_val, st);
        chk("R6 strobes", {wr_link, wr_saved}, 2'b11);
        chk("R8 new status", new_status, 32'h3C5);
        chk("R9 sp_swap", sp_swap, !b32);
        if (!b32) chk("R9 level", sp_save_level, lvl);
        chk("R12 ready busy", req_ready, 0);
        @(negedge clk);
        chk("R11 pulse ends", out_valid, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        req_valid = 1'b0;
        vec_base = 64'hFFFF_0000_0001_0000;
        set_req(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R11 reset out_valid", out_valid, 0);
        chk("R10 reset err", err, 0);
        chk("R12 reset ready", req_ready, 1);
    endtask

    task automatic t_lower64;
        do_req(3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 64'h4000_1000, 32'h0000_0000, 32'h5600_0000, 64'h0);
        do_req(3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 64'h4000_2004, 32'h2000_0000, 32'h0, 64'h0);
        do_req(3'd6, 2'd0, 1'b0, 1'b0, 1'b0, 64'h4000_3008, 32'h8000_0000, 32'h0, 64'h0);
        do_req(3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 64'h4000_400C, 32'h0, 32'h9200_0045, 64'hDEAD_BEEF_CAFE_0010);
    endtask

    task automatic t_lower32;
        do_req(3'd3, 2'd0, 1'b0, 1'b1, 1'b0, 64'h8000, 32'h10, 32'h0000_0001, 64'h0);
        do_req(3'd3, 2'd0, 1'b0, 1'b1, 1'b1, 64'h8002, 32'h30, 32'h0000_0001, 64'h0);
        do_req(3'd5, 2'd0, 1'b0, 1'b1, 1'b0, 64'h8100, 32'h10, 32'h0, 64'h0);
        do_req(3'd0, 2'd0, 1'b1, 1'b1, 1'b1, 64'h8200, 32'h30, 32'h8200_000F, 64'h1234_5678);
    endtask

    task automatic t_current;
        do_req(3'd2, 2'd1, 1'b1, 1'b0, 1'b0, 64'hFFFF_0000_0800_0000, 32'h5, 32'h0, 64'h0);
        do_req(3'd6, 2'd1, 1'b1, 1'b0, 1'b0, 64'hFFFF_0000_0800_0100, 32'h5, 32'h0, 64'h0);
        do_req(3'd5, 2'd1, 1'b0, 1'b0, 1'b0, 64'hFFFF_0000_0800_0200, 32'h4, 32'h0, 64'h0);
        vec_base = 64'h0000_0000_0000_F800;
        do_req(3'd6, 2'd1, 1'b0, 1'b0, 1'b0, 64'h10, 32'h4, 32'h0, 64'h0);
        vec_base = 64'hFFFF_0000_0001_0000;
    endtask

    task automatic t_bad;
        @(negedge clk);
        set_req(3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 64'h777, 32'h1, 32'h1, 64'h1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 err", err, 1);
        chk("R10 no out_valid", out_valid, 0);
        chk("R10 no strobes", {wr_syn, wr_far, wr_link, wr_saved, sp_swap}, 5'b0);
        chk("R12 ready during err", req_ready, 0);
        @(negedge clk);
        chk("R10 err pulse ends", err, 0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        set_req(3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 64'hA000, 32'h0, 32'h0, 64'h0);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R12 first out", out_valid, 1);
        chk("R12 ready low", req_ready, 0);
        chk("R12 first target", target_pc, exp_target(vec_base, 2'd0, 1'b0, 1'b0, 3'd5));
        set_req(3'd6, 2'd1, 1'b1, 1'b0, 1'b0, 64'hB000, 32'h0, 32'h0, 64'h0);
        @(negedge clk);
        chk("R12 gap no pulse", out_valid, 0);
        chk("R12 ready back", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 second out", out_valid, 1);
        chk("R12 second target", target_pc, exp_target(vec_base, 2'd1, 1'b1, 1'b0, 3'd6));
        chk("R12 second link", link_val, 64'hB000);
        @(negedge clk);
        chk("R12 no repeat", out_valid, 0);
        // valid request followed at once by an unknown code
        set_req(3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 64'hC000, 32'h0, 32'h0, 64'h0);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R12 valid before err", out_valid, 1);
        set_req(3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 64'hD000, 32'h0, 32'h0, 64'h0);
        @(negedge clk);
        chk("R10 no err in gap", err, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 err after gap", err, 1);
        chk("R10 link untouched", link_val, 64'hC000);
        @(negedge clk);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_lower64();
        t_lower32();
        t_current();
        t_bad();
        t_collide();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule